// File: doc/BRIEF.md
# I2C Register-Access Slave

This block lets an external I2C master read and write a register file on the chip. It is a slave only. It never drives SCL and never stretches the clock. It acknowledges and returns read data by pulling SDA low through an open-drain enable. SCL and SDA pass through a synchronizer and are oversampled by the system clock, which runs at least 16 times faster than the SCL rate. Start, repeated start and stop conditions are found on the synchronized lines. The block works at both the 100 kHz and the 400 kHz bus rates.

Its 7-bit bus address comes from a 2-bit strap input. The strap is captured only while reset is held. Three strap codes select three addresses that share a fixed upper part. The fourth code turns the I2C slave off, because another port serves the chip in that case.

A write gives the device address, then a 16-bit register pointer sent as two bytes (high byte first), then any number of data bytes. A read first sets the pointer with a write, then sends a repeated start and the device address with the read bit set. The pointer steps forward after every byte that is written or read. The register file sits behind a simple synchronous strobe interface.

Top module: `i2c_regport`

## Requirements
- R1: `mode_sel` is captured only while `rst_n` is low. A change of `mode_sel` after reset has no effect on which address the block answers.
- R2: The device address is 1100000 (0x60) for `mode_sel`=01, 1100001 (0x61) for 10, and 1100010 (0x62) for 11. The address byte is the 7-bit address followed by a direction bit, where 1 means read. Bytes travel MSB first.
- R3: With `mode_sel`=00 the slave is off. It never asserts `sda_pull`, whatever address is sent.
- R4: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A start or repeated start in any state, even in the middle of a byte, restarts address reception. A stop releases SDA and returns the block to idle.
- R5: An address byte that does not match is not acknowledged. All bytes that follow it are then ignored, with no ACK and no register strobe, until the next start or stop.
- R6: The slave pulls SDA low during the ninth clock of a matching address byte, of both pointer bytes, and of every write data byte.
- R7: In a write, the first two bytes after the address load the pointer, high byte first. Each later byte gives exactly one `reg_wr_en` pulse, with `reg_addr` set to the pointer and `reg_wdata` set to the byte.
- R8: The pointer steps by one after each byte written or read, and it wraps from 0xFFFF to 0x0000.
- R9: In a read, the slave shifts out the register at the current pointer MSB first. It changes `sda_pull` only while SCL is low.
- R10: In a read, an ACK from the master (SDA low in the ninth clock) leads to the next register. A NACK ends the read, and the slave keeps SDA released until the next start or stop.
- R11: Each byte read gives one `reg_rd_en` pulse. `reg_rdata` is captured on the second clock edge after the edge that raised the pulse. `reg_wr_en` and `reg_rd_en` are never high together.
- R12: Transfers are correct at SCL half periods of both 16 and 64 system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (oversamples the bus) |
| rst_n | input | 1 | Synchronous active-low reset; strap capture window |
| mode_sel | input | 2 | Address/enable strap, bit 1 is the high strap |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_rd_en | output | 1 | One-cycle register read strobe |
| reg_addr | output | 16 | Register pointer |
| reg_wdata | output | 8 | Write data, valid with reg_wr_en |
| reg_rdata | input | 8 | Read data, valid the cycle after reg_rd_en |

## Verification
The hardest situation to reach from the ports is a repeated start that arrives part way through a byte. Here the slave is in the middle of receiving and must drop its bit count without acknowledging or writing anything. The bench clocks three loose bits after a pointer byte, then raises SDA while SCL is low and issues a new start. It then expects a normal acknowledged write at a fresh address. A second hard case is the bus after a master NACK, where the slave must stay silent. The bench clocks one more whole byte with SDA released and expects to read back all ones. Random write and readback rounds at two SCL rates cover pointer stepping across different lengths and addresses.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;
  localparam int RA_W = 16;
  localparam int DW   = 8;

  typedef enum logic [2:0] {
    PH_IDLE, PH_DEV, PH_RHI, PH_RLO, PH_WDAT, PH_RDAT, PH_MACK, PH_HOLD
  } phase_e;

  // strap code 01,10,11 -> low address bits 00,01,10
  function automatic logic [6:0] strap_to_dev(input logic [4:0] base, input logic [1:0] sel);
    return {base, sel - 2'd1};
  endfunction

  function automatic logic strap_live(input logic [1:0] sel);
    return |sel;
  endfunction

  function automatic logic [RA_W-1:0] ptr_step(input logic [RA_W-1:0] p);
    return p + 1'b1;
  endfunction
endpackage

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_hi,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_seen,
  output logic stop_seen
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] scl_sh, sda_sh;
  logic         scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[TOP-1:0], scl_i};
      sda_sh <= {sda_sh[TOP-1:0], sda_i};
      scl_d  <= scl_sh[TOP];
      sda_d  <= sda_sh[TOP];
    end
  end

  assign scl_hi     = scl_sh[TOP];
  assign sda_lvl    = sda_sh[TOP];
  assign scl_rise   = scl_hi & ~scl_d;
  assign scl_fall   = ~scl_hi & scl_d;
  assign start_seen = scl_hi & scl_d & sda_d & ~sda_lvl;
  assign stop_seen  = scl_hi & scl_d & ~sda_d & sda_lvl;

  // R4: a condition is never flagged on the same cycle as an SCL edge
  p_cond_off_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_seen || stop_seen) |-> !(scl_rise || scl_fall));
endmodule

// File: rtl/i2c_strap_latch.sv
module i2c_strap_latch
  import i2c_regport_pkg::*;
#(
  parameter logic [4:0] ADDR_BASE = 5'b11000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  output logic [6:0] dev_addr,
  output logic       slave_en
);
  logic [1:0] sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= sel;
  end

  assign dev_addr = strap_to_dev(ADDR_BASE, sel_q);
  assign slave_en = strap_live(sel_q);

  p_strap_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(sel_q));
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
  import i2c_regport_pkg::*;
#(
  parameter logic [4:0] ADDR_BASE   = 5'b11000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode_sel,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_pull,
  output logic            reg_wr_en,
  output logic            reg_rd_en,
  output logic [RA_W-1:0] reg_addr,
  output logic [DW-1:0]   reg_wdata,
  input  logic [DW-1:0]   reg_rdata
);
  localparam logic [3:0] BITS = 4'(DW);

  logic scl_hi, sda_lvl, scl_rise, scl_fall, start_seen, stop_seen;
  logic [6:0] dev_addr;
  logic       slave_en;

  i2c_bus_watch #(.SYNC_STAGES(SYNC_STAGES)) u_watch (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_hi(scl_hi), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_seen(start_seen), .stop_seen(stop_seen)
  );

  i2c_strap_latch #(.ADDR_BASE(ADDR_BASE)) u_strap (
    .clk(clk), .rst_n(rst_n), .sel(mode_sel), .dev_addr(dev_addr), .slave_en(slave_en)
  );

  phase_e          phase;
  logic            in_ack, is_read, pull_q, wr_q, rd_q, rd_wait;
  logic [3:0]      bitcnt;
  logic [DW-1:0]   rx_sh, tx_sh;
  logic [RA_W-1:0] ptr;

  // named internal events
  logic rx_phase, byte_done, addr_hit;
  assign rx_phase  = (phase == PH_DEV) || (phase == PH_RHI) ||
                     (phase == PH_RLO) || (phase == PH_WDAT);
  assign byte_done = scl_fall && rx_phase && !in_ack && (bitcnt == BITS);
  assign addr_hit  = slave_en && (rx_sh[7:1] == dev_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      in_ack  <= 1'b0;
      is_read <= 1'b0;
      pull_q  <= 1'b0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      rd_wait <= 1'b0;
      bitcnt  <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      ptr     <= '0;
    end else begin
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      rd_wait <= rd_q;
      if (wr_q || rd_q) ptr <= ptr_step(ptr);
      if (rd_wait) tx_sh <= reg_rdata;

      if (stop_seen) begin
        phase  <= PH_IDLE;
        in_ack <= 1'b0;
        pull_q <= 1'b0;
      end else if (start_seen) begin
        phase  <= PH_DEV;
        in_ack <= 1'b0;
        bitcnt <= '0;
        pull_q <= 1'b0;
      end else if (scl_rise) begin
        if (rx_phase && !in_ack && bitcnt != BITS) begin
          rx_sh  <= {rx_sh[DW-2:0], sda_lvl};
          bitcnt <= bitcnt + 4'd1;
        end else if (phase == PH_MACK) begin
          if (sda_lvl) phase <= PH_HOLD;
          else begin
            rd_q   <= 1'b1;
            phase  <= PH_RDAT;
            bitcnt <= '0;
          end
        end
      end else if (scl_fall) begin
        if (in_ack) begin
          in_ack <= 1'b0;
          pull_q <= 1'b0;
          bitcnt <= '0;
          unique case (phase)
            PH_DEV: begin
              if (is_read) begin
                pull_q <= ~tx_sh[DW-1];
                tx_sh  <= {tx_sh[DW-2:0], 1'b0};
                bitcnt <= 4'd1;
                phase  <= PH_RDAT;
              end else phase <= PH_RHI;
            end
            PH_RHI:  phase <= PH_RLO;
            PH_RLO:  phase <= PH_WDAT;
            default: phase <= PH_WDAT;
          endcase
        end else if (byte_done) begin
          unique case (phase)
            PH_DEV: begin
              if (addr_hit) begin
                in_ack  <= 1'b1;
                pull_q  <= 1'b1;
                is_read <= rx_sh[0];
                rd_q    <= rx_sh[0];
              end else phase <= PH_HOLD;
            end
            PH_RHI: begin
              ptr[RA_W-1:RA_W-DW] <= rx_sh;
              in_ack <= 1'b1;
              pull_q <= 1'b1;
            end
            PH_RLO: begin
              ptr[DW-1:0] <= rx_sh;
              in_ack <= 1'b1;
              pull_q <= 1'b1;
            end
            default: begin
              wr_q   <= 1'b1;
              in_ack <= 1'b1;
              pull_q <= 1'b1;
            end
          endcase
        end else if (phase == PH_RDAT) begin
          if (bitcnt == BITS) begin
            pull_q <= 1'b0;
            phase  <= PH_MACK;
          end else begin
            pull_q <= ~tx_sh[DW-1];
            tx_sh  <= {tx_sh[DW-2:0], 1'b0};
            bitcnt <= bitcnt + 4'd1;
          end
        end
      end
    end
  end

  assign sda_pull  = pull_q;
  assign reg_wr_en = wr_q;
  assign reg_rd_en = rd_q;
  assign reg_addr  = ptr;
  assign reg_wdata = rx_sh;

  // R9: the open-drain enable only moves while synchronized SCL is low
  p_pull_moves_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pull_q) |-> !scl_hi);
  // R3: disabled slave stays off the bus
  p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !slave_en |-> !sda_pull);
  // R11: strobes never overlap
  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_rd_en));
  // R8: pointer steps by one after each strobe
  p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en || reg_rd_en) |=> (reg_addr == $past(reg_addr) + 16'd1));
  // R4: stop releases the line and idles; start rearms address reception
  p_stop_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> (!sda_pull && phase == PH_IDLE));
  p_start_rearm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |=> (phase == PH_DEV && !in_ack && !sda_pull));
  // R5/R10: ignoring state never drives the line
  p_hold_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HOLD) |-> !sda_pull);
endmodule

// File: tb/i2c_regport_bench.sv
module i2c_regport_bench;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_sel = 2'b01;
  logic        scl_m = 1'b1, sda_m = 1'b1;
  logic        sda_pull, reg_wr_en, reg_rd_en;
  logic [15:0] reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  wire         sda_line = sda_m & ~sda_pull;

  always #(CLK_NS/2) clk = ~clk;

  i2c_regport u_i2c_regport (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull(sda_pull), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // register file environment
  logic [7:0]  regs [256];
  logic [7:0]  exp_regs [256];
  logic [15:0] wr_log [8];
  int wr_cnt = 0, rd_cnt = 0, oe_cnt = 0;
  int checks = 0, errors = 0;
  bit done = 0;
  int h = 16, q = 4;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];

  always_ff @(posedge clk) begin
    if (reg_wr_en) begin
      regs[reg_addr[7:0]] <= reg_wdata;
      wr_log[wr_cnt % 8]  <= reg_addr;
      wr_cnt <= wr_cnt + 1;
    end
    if (reg_rd_en) begin
      reg_rdata <= regs[reg_addr[7:0]];
      rd_cnt <= rd_cnt + 1;
    end
    if (sda_pull) oe_cnt <= oe_cnt + 1;
  end

  function automatic logic [6:0] want_dev(input logic [1:0] s);
    case (s)
      2'b01:   return 7'h60;
      2'b10:   return 7'h61;
      default: return 7'h62;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_rate(input int half);
    h = half; q = half / 4;
  endtask

  task automatic do_reset(input logic [1:0] s);
    mode_sel = s; rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    tick(5);
    rst_n = 1'b1;
    tick(5);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(q);
    scl_m = 1'b1; tick(h);
    sda_m = 1'b0; tick(h);
    scl_m = 1'b0; tick(h - q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(q);
    scl_m = 1'b1; tick(h);
    sda_m = 1'b1; tick(h);
  endtask

  task automatic clock_bit(input logic b);
    sda_m = b; tick(q);
    scl_m = 1'b1; tick(h);
    scl_m = 1'b0; tick(h - q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) clock_bit(b[i]);
    sda_m = 1'b1; tick(q);
    scl_m = 1'b1; tick(h / 2);
    acked = !sda_line;
    tick(h - h / 2);
    scl_m = 1'b0; tick(h - q);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      tick(q);
      scl_m = 1'b1; tick(h / 2);
      b = {b[6:0], sda_line};
      tick(h - h / 2);
      scl_m = 1'b0; tick(h - q);
    end
    clock_bit(!mack);
    sda_m = 1'b1;
  endtask

  task automatic wr_txn(input logic [6:0] dev, input logic [15:0] a, input int n, output int misses);
    bit ak;
    misses = 0;
    bus_start();
    send_byte({dev, 1'b0}, ak); if (!ak) misses++;
    send_byte(a[15:8], ak);     if (!ak) misses++;
    send_byte(a[7:0], ak);      if (!ak) misses++;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ak); if (!ak) misses++;
    end
    bus_stop();
  endtask

  task automatic rd_txn(input logic [6:0] dev, input logic [15:0] a, input int n, output int misses);
    bit ak;
    logic [7:0] b;
    misses = 0;
    bus_start();
    send_byte({dev, 1'b0}, ak); if (!ak) misses++;
    send_byte(a[15:8], ak);     if (!ak) misses++;
    send_byte(a[7:0], ak);      if (!ak) misses++;
    bus_start();
    send_byte({dev, 1'b1}, ak); if (!ak) misses++;
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      rbuf[i] = b;
    end
    bus_stop();
  endtask

  task automatic probe(input logic [6:0] dev, output bit ak);
    bus_start();
    send_byte({dev, 1'b0}, ak);
    bus_stop();
  endtask

  task automatic rand_round(input logic [6:0] dev, input int rounds, input string tag);
    logic [15:0] a;
    int len, nk;
    for (int t = 0; t < rounds; t++) begin
      a   = 16'($urandom);
      len = 1 + int'($urandom % 4);
      for (int i = 0; i < len; i++) wbuf[i] = 8'($urandom);
      wr_txn(dev, a, len, nk);
      chk(nk == 0, {tag, " R6 write acks"}, nk, 0);
      for (int i = 0; i < len; i++) exp_regs[8'(a + 16'(i))] = wbuf[i];
      rd_txn(dev, a, len, nk);
      chk(nk == 0, {tag, " R6 read setup acks"}, nk, 0);
      for (int i = 0; i < len; i++)
        chk(rbuf[i] == exp_regs[8'(a + 16'(i))], {tag, " R9 readback"}, rbuf[i], exp_regs[8'(a + 16'(i))]);
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ak;
    int nk, w0, r0, o0;
    logic [7:0] b;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 256; i++) begin regs[i] = 8'h00; exp_regs[i] = 8'h00; end
    set_rate(16);

    // reset state
    do_reset(2'b01);
    chk(!sda_pull && !reg_wr_en && !reg_rd_en, "R4 reset outputs idle",
        {sda_pull, reg_wr_en, reg_rd_en}, 0);

    // R2 address mapping per strap code
    for (int s = 1; s < 4; s++) begin
      do_reset(2'(s));
      probe(want_dev(2'(s)), ak);
      chk(ak, "R2 matching address acked", ak, 1);
      probe(want_dev(2'(s)) ^ 7'h03, ak);
      chk(!ak, "R2 other address not acked", ak, 0);
    end

    // R3 disabled slave
    do_reset(2'b00);
    o0 = oe_cnt;
    for (int d = 0; d < 3; d++) begin
      probe(7'h60 + 7'(d), ak);
      chk(!ak, "R3 disabled slave silent", ak, 0);
    end
    chk(oe_cnt == o0, "R3 sda_pull never asserted", oe_cnt - o0, 0);

    // R1 strap change after reset ignored
    do_reset(2'b01);
    mode_sel = 2'b11;
    probe(7'h60, ak);
    chk(ak, "R1 latched address still answers", ak, 1);
    probe(7'h62, ak);
    chk(!ak, "R1 new strap address ignored", ak, 0);

    // R7 R6 directed write
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h96;
    w0 = wr_cnt;
    wr_txn(7'h60, 16'h1234, 3, nk);
    for (int i = 0; i < 3; i++) exp_regs[8'h34 + 8'(i)] = wbuf[i];
    chk(nk == 0, "R6 all write bytes acked", nk, 0);
    chk(wr_cnt - w0 == 3, "R7 one strobe per data byte", wr_cnt - w0, 3);
    chk(wr_log[(w0 + 2) % 8] == 16'h1236, "R8 third write address", wr_log[(w0 + 2) % 8], 16'h1236);
    chk(regs[8'h35] == 8'h3C, "R7 write data landed", regs[8'h35], 8'h3C);

    // R8 pointer wrap
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    w0 = wr_cnt;
    wr_txn(7'h60, 16'hFFFF, 2, nk);
    exp_regs[8'hFF] = 8'h11; exp_regs[8'h00] = 8'h22;
    chk(wr_log[w0 % 8] == 16'hFFFF, "R8 write at top", wr_log[w0 % 8], 16'hFFFF);
    chk(wr_log[(w0 + 1) % 8] == 16'h0000, "R8 wrap to zero", wr_log[(w0 + 1) % 8], 0);

    // R9 R11 readback
    r0 = rd_cnt;
    rd_txn(7'h60, 16'h1234, 3, nk);
    chk(nk == 0, "R6 read setup acks", nk, 0);
    chk(rd_cnt - r0 == 3, "R11 one read strobe per byte", rd_cnt - r0, 3);
    for (int i = 0; i < 3; i++)
      chk(rbuf[i] == exp_regs[8'h34 + 8'(i)], "R9 read data", rbuf[i], exp_regs[8'h34 + 8'(i)]);

    // R10 NACK then extra clocks: slave must stay released
    bus_start();
    send_byte({7'h60, 1'b0}, ak);
    send_byte(8'h12, ak);
    send_byte(8'h35, ak);
    bus_start();
    send_byte({7'h60, 1'b1}, ak);
    recv_byte(1'b0, b);
    chk(b == 8'h3C, "R10 byte before NACK", b, 8'h3C);
    o0 = oe_cnt;
    recv_byte(1'b0, b);
    chk(b == 8'hFF, "R10 line released after NACK", b, 8'hFF);
    chk(oe_cnt == o0, "R10 no pull after NACK", oe_cnt - o0, 0);
    bus_stop();

    // R5 mismatched address ignores data
    w0 = wr_cnt;
    bus_start();
    send_byte({7'h64, 1'b0}, ak);
    chk(!ak, "R5 mismatch not acked", ak, 0);
    nk = 0;
    for (int i = 0; i < 4; i++) begin send_byte(8'h00, ak); if (ak) nk++; end
    bus_stop();
    chk(nk == 0, "R5 trailing bytes not acked", nk, 0);
    chk(wr_cnt == w0, "R5 no writes", wr_cnt - w0, 0);

    // R4 stop mid-transfer, then restart inside a byte
    bus_start();
    send_byte({7'h60, 1'b0}, ak);
    send_byte(8'hAB, ak);
    bus_stop();
    chk(!sda_pull, "R4 stop releases line", sda_pull, 0);
    w0 = wr_cnt;
    bus_start();
    send_byte({7'h60, 1'b0}, ak);
    send_byte(8'h77, ak);
    clock_bit(1'b0); clock_bit(1'b1); clock_bit(1'b0);
    bus_start();
    send_byte({7'h60, 1'b0}, ak);
    chk(ak, "R4 restart mid-byte re-addresses", ak, 1);
    send_byte(8'h00, ak);
    send_byte(8'h42, ak);
    send_byte(8'h5A, ak);
    bus_stop();
    exp_regs[8'h42] = 8'h5A;
    chk(wr_cnt - w0 == 1, "R4 single write after restart", wr_cnt - w0, 1);
    chk(wr_log[w0 % 8] == 16'h0042, "R4 pointer after restart", wr_log[w0 % 8], 16'h0042);

    // R12 random rounds at two bus rates
    set_rate(64);
    do_reset(2'b10);
    rand_round(7'h61, 3, "R12 slow");
    set_rate(16);
    do_reset(2'b11);
    rand_round(7'h62, 12, "R12 fast");

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule